// File: doc/BRIEF.md
# Dual-Width Message Mailbox

This block is a shared message store that sits between a small group of 32-bit processing cores and a wide on-chip network. Each message is 64 bytes long. Cores see the store as 32-bit words. The network side moves a whole 512-bit message per cycle in each direction, with a valid/ready handshake. The same storage holds the messages the cores are building for transmission and the messages that have arrived for them.

Each core owns a fixed group of slots. Local slot 0 of each group is the core's transmit staging slot. The other local slots receive arrivals. An arriving message carries a destination core number. It is written whole into the lowest free receive slot of that core, and the slot's local index is appended to that core's receive queue. A core can poll a status word. It can release the message at the head of its queue, or send its staging slot. It can also forward the head message: the slot is taken out of the receive queue and transmitted as it stands, with no word-by-word copy, and it is freed once the network has taken it.

A send is only accepted when nothing from that core is already waiting for the network. Otherwise the command is refused, and the core decides whether to retry, drop or change the message. Accepted sends from different cores reach the network port in round-robin order.

Top module: `mbx_mailbox`

## Requirements
- R1: After reset `net_tx_valid` is 0, `net_rx_ready` is 1 for every destination core, and a core's status word reads 0x2.
- R2: A core-side write (op 1) to address {local slot, word index} stores a 32-bit word. A read (op 0) of the same address returns it on `cpu_rdata` one clock after the request. Core `cpu_id` reaches only its own slot group.
- R3: An accepted arrival is stored whole in the lowest-numbered free receive slot (local 1 and up) of `net_rx_dest`. The status word (op 2) then shows bit 0 = 1 and, in bits [4 +: slot-index width], the local index of the head receive slot.
- R4: When the destination core has no free receive slot, `net_rx_ready` is 0 for that destination and the message is not taken. Other destinations are unaffected.
- R5: Send (op 3) is answered with `cpu_ok` = 1 when the core has no transmission waiting. The contents of local slot 0 then appear on `net_tx_data`, with `net_tx_src` equal to the core number. Status bit 1 reads 0 until the handshake completes.
- R6: A send or forward issued while that core already has a transmission waiting is refused with `cpu_ok` = 0, and no extra message is emitted.
- R7: While `net_tx_valid` is 1 and `net_tx_ready` is 0, valid, source and data stay unchanged.
- R8: Release (op 4) removes the head receive slot and frees it, with `cpu_ok` = 1. A release with an empty queue gives `cpu_ok` = 0.
- R9: Forward (op 5) removes the head receive slot and transmits its unchanged contents from that core. The slot stays occupied until the network handshake and is free afterwards.
- R10: Waiting transmissions from different cores are granted in round-robin order, starting after the core granted last.
- R11: Receive slots of a core are presented in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Core-side request strobe |
| cpu_id | input | 2 | Requesting core number |
| cpu_op | input | 3 | 0 read, 1 write, 2 status, 3 send, 4 release, 5 forward |
| cpu_addr | input | 6 | {local slot (2), word index (4)} |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read or status data, one cycle after request |
| cpu_ok | output | 1 | Command accepted, one cycle after request |
| net_rx_valid | input | 1 | Arriving message valid |
| net_rx_dest | input | 2 | Destination core of arriving message |
| net_rx_data | input | 512 | Arriving message |
| net_rx_ready | output | 1 | Destination has a free receive slot |
| net_tx_valid | output | 1 | Outgoing message valid |
| net_tx_src | output | 2 | Core that issued the outgoing message |
| net_tx_data | output | 512 | Outgoing message |
| net_tx_ready | input | 1 | Network accepts the outgoing message |

## Verification
The embedded properties watch, on every cycle, that an outgoing message stays unchanged while the network stalls it, that a valid transmission always belongs to a core with a waiting send, that a forwarded slot is free right after its handshake, that no staging slot is ever marked as received, and that no receive queue overflows or underflows. The directed scenarios are the only way to show the data-path results: which free slot an arrival lands in, the order of queued slots, refusals of repeated sends, backpressure once a core's group is full, and the grant order among several cores.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int DEF_MSG_W  = 512;
    localparam int DEF_WORD_W = 32;

    typedef enum logic [2:0] {
        OP_RD   = 3'd0,
        OP_WR   = 3'd1,
        OP_STAT = 3'd2,
        OP_SEND = 3'd3,
        OP_REL  = 3'd4,
        OP_FWD  = 3'd5
    } mbx_op_e;
endpackage

// File: rtl/mbx_store.sv
module mbx_store #(
    parameter int NSLOTS = 16,
    parameter int MSG_W  = 512,
    parameter int WORD_W = 32,
    localparam int WORDS = MSG_W / WORD_W,
    localparam int SW    = $clog2(NSLOTS),
    localparam int WW    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              wr_w_en,
    input  logic [SW-1:0]     wr_w_slot,
    input  logic [WW-1:0]     wr_w_idx,
    input  logic [WORD_W-1:0] wr_w_data,
    input  logic              wr_m_en,
    input  logic [SW-1:0]     wr_m_slot,
    input  logic [MSG_W-1:0]  wr_m_data,
    input  logic [SW-1:0]     rd_w_slot,
    input  logic [WW-1:0]     rd_w_idx,
    output logic [WORD_W-1:0] rd_w_data,
    input  logic [SW-1:0]     rd_m_slot,
    output logic [MSG_W-1:0]  rd_m_data
);
    logic [MSG_W-1:0] mem_q [NSLOTS];

    // wide port writes a whole message, narrow port one word
    always_ff @(posedge clk) begin
        if (wr_m_en)
            mem_q[wr_m_slot] <= wr_m_data;
        if (wr_w_en)
            mem_q[wr_w_slot][int'(wr_w_idx)*WORD_W +: WORD_W] <= wr_w_data;
    end

    assign rd_w_data = mem_q[rd_w_slot][int'(rd_w_idx)*WORD_W +: WORD_W];
    assign rd_m_data = mem_q[rd_m_slot];
endmodule

// File: rtl/mbx_idx_fifo.sv
module mbx_idx_fifo #(
    parameter int DEPTH = 3,
    parameter int W     = 2,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNW  = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_val,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] ent;
        logic [PW-1:0]           rp;
        logic [PW-1:0]           wp;
        logic [CNW-1:0]          cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     full;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.ent[st_q.wp] = push_val;
            st_d.wp           = wrap_inc(st_q.wp);
        end
        if (pop)
            st_d.rp = wrap_inc(st_q.rp);
        st_d.cnt = st_q.cnt + CNW'(push) - CNW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.ent[st_q.rp];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CNW'(DEPTH));

    AST_Q_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full && !pop)); // R4
    AST_Q_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R8
endmodule

// File: rtl/mbx_rr_pick.sv
module mbx_rr_pick #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic [IW-1:0] gnt,
    output logic          any
);
    int unsigned idx;

    // search starts one past the previous winner and wraps
    always_comb begin
        any = 1'b0;
        gnt = '0;
        idx = 0;
        for (int k = 1; k <= N; k++) begin
            idx = (int'(last) + k) % N;
            if (!any && req[idx]) begin
                any = 1'b1;
                gnt = IW'(idx);
            end
        end
    end
endmodule

// File: rtl/mbx_mailbox.sv
module mbx_mailbox
    import mbx_pkg::*;
#(
    parameter int NUM_CORES      = 4,
    parameter int SLOTS_PER_CORE = 4,
    parameter int MSG_W          = DEF_MSG_W,
    parameter int WORD_W         = DEF_WORD_W,
    localparam int NSLOTS = NUM_CORES * SLOTS_PER_CORE,
    localparam int SW     = $clog2(NSLOTS),
    localparam int LW     = $clog2(SLOTS_PER_CORE),
    localparam int CW     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int WORDS  = MSG_W / WORD_W,
    localparam int WW     = $clog2(WORDS),
    localparam int QD     = SLOTS_PER_CORE - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [CW-1:0]     cpu_id,
    input  logic [2:0]        cpu_op,
    input  logic [LW+WW-1:0]  cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_ok,
    input  logic              net_rx_valid,
    input  logic [CW-1:0]     net_rx_dest,
    input  logic [MSG_W-1:0]  net_rx_data,
    output logic              net_rx_ready,
    output logic              net_tx_valid,
    output logic [CW-1:0]     net_tx_src,
    output logic [MSG_W-1:0]  net_tx_data,
    input  logic              net_tx_ready
);
    typedef struct packed {
        logic [NSLOTS-1:0]             busy;   // receive slot occupied
        logic [NUM_CORES-1:0]          pend;   // transmission waiting
        logic [NUM_CORES-1:0][LW-1:0]  pslot;  // local slot to transmit
        logic [NUM_CORES-1:0]          pfwd;   // free slot after handshake
        logic                          txv;
        logic [CW-1:0]                 txc;
        logic [CW-1:0]                 last;
        logic [WORD_W-1:0]             rdata;
        logic                          ok;
    } mbx_st_t;

    mbx_st_t st_d, st_q;

    function automatic logic [SW-1:0] phys(input logic [CW-1:0] c, input logic [LW-1:0] l);
        return SW'(int'(c) * SLOTS_PER_CORE + int'(l));
    endfunction

    // ---------------- decode ----------------
    mbx_op_e       op;
    logic [LW-1:0] cpu_loc;
    logic [WW-1:0] cpu_widx;
    assign op       = mbx_op_e'(cpu_op);
    assign cpu_loc  = cpu_addr[WW +: LW];
    assign cpu_widx = cpu_addr[WW-1:0];

    // ---------------- receive queues ----------------
    logic [NUM_CORES-1:0]         q_push, q_pop, q_empty;
    logic [NUM_CORES-1:0][LW-1:0] q_head;
    logic [LW-1:0]                rx_loc;
    logic                         rx_found, rx_acc;

    generate
        for (genvar c = 0; c < NUM_CORES; c++) begin : g_q
            mbx_idx_fifo #(.DEPTH(QD), .W(LW)) u_q (
                .clk      (clk),
                .rst_n    (rst_n),
                .push     (q_push[c]),
                .push_val (rx_loc),
                .pop      (q_pop[c]),
                .head     (q_head[c]),
                .empty    (q_empty[c])
            );
            AST_STAGE_NEVER_RX: assert property (@(posedge clk) disable iff (!rst_n)
                !st_q.busy[c*SLOTS_PER_CORE]); // R3
        end
    endgenerate

    // lowest free receive slot of the destination core
    always_comb begin
        rx_found = 1'b0;
        rx_loc   = '0;
        for (int l = SLOTS_PER_CORE - 1; l >= 1; l--) begin
            if (!st_q.busy[phys(net_rx_dest, LW'(l))]) begin
                rx_found = 1'b1;
                rx_loc   = LW'(l);
            end
        end
    end

    assign net_rx_ready = rx_found;
    assign rx_acc       = net_rx_valid && rx_found;

    always_comb begin
        q_push = '0;
        if (rx_acc) q_push[net_rx_dest] = 1'b1;
    end

    // ---------------- arbitration ----------------
    logic [CW-1:0] rr_gnt;
    logic          rr_any;

    mbx_rr_pick #(.N(NUM_CORES)) u_rr (
        .req  (st_q.pend),
        .last (st_q.last),
        .gnt  (rr_gnt),
        .any  (rr_any)
    );

    // ---------------- storage ----------------
    logic              wr_w_en;
    logic [WORD_W-1:0] rd_word;
    logic [SW-1:0]     tx_phys;

    assign tx_phys = phys(st_q.txc, st_q.pslot[st_q.txc]);

    mbx_store #(.NSLOTS(NSLOTS), .MSG_W(MSG_W), .WORD_W(WORD_W)) u_store (
        .clk       (clk),
        .wr_w_en   (wr_w_en),
        .wr_w_slot (phys(cpu_id, cpu_loc)),
        .wr_w_idx  (cpu_widx),
        .wr_w_data (cpu_wdata),
        .wr_m_en   (rx_acc),
        .wr_m_slot (phys(net_rx_dest, rx_loc)),
        .wr_m_data (net_rx_data),
        .rd_w_slot (phys(cpu_id, cpu_loc)),
        .rd_w_idx  (cpu_widx),
        .rd_w_data (rd_word),
        .rd_m_slot (tx_phys),
        .rd_m_data (net_tx_data)
    );

    // ---------------- next state ----------------
    logic [LW-1:0]     my_head;
    logic              my_empty;
    logic [WORD_W-1:0] status;

    assign my_head  = q_head[cpu_id];
    assign my_empty = q_empty[cpu_id];

    always_comb begin
        status         = '0;
        status[0]      = !my_empty;
        status[1]      = !st_q.pend[cpu_id];
        status[4 +: LW] = my_head;
    end

    always_comb begin
        st_d    = st_q;
        st_d.ok = 1'b0;
        q_pop   = '0;
        wr_w_en = 1'b0;

        if (rx_acc)
            st_d.busy[phys(net_rx_dest, rx_loc)] = 1'b1;

        if (cpu_req) begin
            unique case (op)
                OP_RD: begin
                    st_d.rdata = rd_word;
                    st_d.ok    = 1'b1;
                end
                OP_WR: begin
                    wr_w_en = 1'b1;
                    st_d.ok = 1'b1;
                end
                OP_STAT: begin
                    st_d.rdata = status;
                    st_d.ok    = 1'b1;
                end
                OP_SEND: begin
                    if (!st_q.pend[cpu_id]) begin
                        st_d.pend[cpu_id]  = 1'b1;
                        st_d.pslot[cpu_id] = '0;
                        st_d.pfwd[cpu_id]  = 1'b0;
                        st_d.ok            = 1'b1;
                    end
                end
                OP_REL: begin
                    if (!my_empty) begin
                        q_pop[cpu_id]                  = 1'b1;
                        st_d.busy[phys(cpu_id, my_head)] = 1'b0;
                        st_d.ok                        = 1'b1;
                    end
                end
                OP_FWD: begin
                    if (!my_empty && !st_q.pend[cpu_id]) begin
                        q_pop[cpu_id]      = 1'b1;
                        st_d.pend[cpu_id]  = 1'b1;
                        st_d.pslot[cpu_id] = my_head;
                        st_d.pfwd[cpu_id]  = 1'b1;
                        st_d.ok            = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        if (st_q.txv && net_tx_ready) begin
            st_d.txv            = 1'b0;
            st_d.pend[st_q.txc] = 1'b0;
            if (st_q.pfwd[st_q.txc])
                st_d.busy[tx_phys] = 1'b0;
        end else if (!st_q.txv && rr_any) begin
            st_d.txv  = 1'b1;
            st_d.txc  = rr_gnt;
            st_d.last = rr_gnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cpu_rdata    = st_q.rdata;
    assign cpu_ok       = st_q.ok;
    assign net_tx_valid = st_q.txv;
    assign net_tx_src   = st_q.txc;

    // ---------------- properties ----------------
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (net_tx_valid && !net_tx_ready) |=>
            (net_tx_valid && $stable(net_tx_src) && $stable(net_tx_data))); // R7
    AST_TX_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        net_tx_valid |-> st_q.pend[net_tx_src]); // R5
    AST_FWD_FREED: assert property (@(posedge clk) disable iff (!rst_n)
        (net_tx_valid && net_tx_ready && st_q.pfwd[net_tx_src]) |=>
            !st_q.busy[$past(tx_phys)]); // R9
endmodule

// File: tb/sim_mbx_mailbox.sv
module sim_mbx_mailbox;
    localparam int NC = 4;
    localparam int CW = 2;
    localparam int AW = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req = 1'b0;
    logic [CW-1:0] cpu_id = '0;
    logic [2:0]   cpu_op = '0;
    logic [AW-1:0] cpu_addr = '0;
    logic [31:0]  cpu_wdata = '0;
    logic [31:0]  cpu_rdata;
    logic         cpu_ok;
    logic         net_rx_valid = 1'b0;
    logic [CW-1:0] net_rx_dest = '0;
    logic [511:0] net_rx_data = '0;
    logic         net_rx_ready;
    logic         net_tx_valid;
    logic [CW-1:0] net_tx_src;
    logic [511:0] net_tx_data;
    logic         net_tx_ready = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mbx_mailbox u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_id(cpu_id), .cpu_op(cpu_op), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ok(cpu_ok),
        .net_rx_valid(net_rx_valid), .net_rx_dest(net_rx_dest), .net_rx_data(net_rx_data),
        .net_rx_ready(net_rx_ready),
        .net_tx_valid(net_tx_valid), .net_tx_src(net_tx_src), .net_tx_data(net_tx_data),
        .net_tx_ready(net_tx_ready)
    );

    function automatic logic [511:0] mk(input logic [15:0] seed);
        logic [511:0] m;
        for (int i = 0; i < 16; i++) m[i*32 +: 32] = {seed, 16'(i * 16'h0111)};
        return m;
    endfunction

    task automatic chk(input bit cond, input string tag, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cpu(input logic [2:0] op, input int id, input int loc, input int widx,
                       input logic [31:0] wd, output logic [31:0] rd, output logic ok);
        @(negedge clk);
        cpu_req   = 1'b1;
        cpu_op    = op;
        cpu_id    = CW'(id);
        cpu_addr  = {2'(loc), 4'(widx)};
        cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        rd = cpu_rdata;
        ok = cpu_ok;
    endtask

    task automatic load_stage(input int id, input logic [511:0] m);
        logic [31:0] rd; logic ok;
        for (int i = 0; i < 16; i++) cpu(3'd1, id, 0, i, m[i*32 +: 32], rd, ok);
    endtask

    task automatic rx_push(input int dest, input logic [511:0] m, output logic rdy);
        @(negedge clk);
        net_rx_valid = 1'b1;
        net_rx_dest  = CW'(dest);
        net_rx_data  = m;
        #1 rdy = net_rx_ready;
        @(negedge clk);
        net_rx_valid = 1'b0;
    endtask

    task automatic probe_ready(input int dest, output logic rdy);
        @(negedge clk);
        net_rx_dest = CW'(dest);
        #1 rdy = net_rx_ready;
    endtask

    task automatic tx_take(input int src, input logic [511:0] m, input string tag);
        int n = 0;
        while (!net_tx_valid && n < 20) begin @(negedge clk); n++; end
        chk(net_tx_valid === 1'b1, {tag, " valid"}, 512'(net_tx_valid), 512'(1));
        chk(net_tx_src == CW'(src), {tag, " src"}, 512'(net_tx_src), 512'(src));
        chk(net_tx_data == m, {tag, " data"}, net_tx_data, m);
        net_tx_ready = 1'b1;
        @(negedge clk);
        net_tx_ready = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] rd; logic ok; logic r;
        @(negedge clk);
        chk(net_tx_valid === 1'b0, "R1 tx idle", 512'(net_tx_valid), 0);
        for (int d = 0; d < NC; d++) begin
            probe_ready(d, r);
            chk(r === 1'b1, "R1 rx ready", 512'(r), 512'(1));
        end
        cpu(3'd2, 0, 0, 0, 0, rd, ok);
        chk(rd == 32'h2, "R1 status", 512'(rd), 512'(2));
    endtask

    task automatic t_word_rw();
        logic [31:0] rd; logic ok;
        cpu(3'd1, 0, 0, 3, 32'hAAAA_0003, rd, ok);
        cpu(3'd1, 1, 0, 3, 32'hBBBB_0003, rd, ok);
        cpu(3'd1, 1, 2, 15, 32'hCCCC_00FF, rd, ok);
        cpu(3'd0, 0, 0, 3, 0, rd, ok);
        chk(rd == 32'hAAAA_0003, "R2 own group", 512'(rd), 512'(32'hAAAA_0003));
        cpu(3'd0, 1, 0, 3, 0, rd, ok);
        chk(rd == 32'hBBBB_0003, "R2 readback", 512'(rd), 512'(32'hBBBB_0003));
        cpu(3'd0, 1, 2, 15, 0, rd, ok);
        chk(rd == 32'hCCCC_00FF, "R2 last word", 512'(rd), 512'(32'hCCCC_00FF));
    endtask

    task automatic t_arrival();
        logic [31:0] rd; logic ok; logic r;
        rx_push(0, mk(16'h0A01), r);
        rx_push(0, mk(16'h0A02), r);
        cpu(3'd2, 0, 0, 0, 0, rd, ok);
        chk(rd == 32'h13, "R3 status head 1", 512'(rd), 512'(32'h13));
        cpu(3'd0, 0, 1, 5, 0, rd, ok);
        chk(rd == mk(16'h0A01)[5*32 +: 32], "R3 slot1 word5", 512'(rd), 512'(mk(16'h0A01)[5*32 +: 32]));
        cpu(3'd4, 0, 0, 0, 0, rd, ok);
        chk(ok === 1'b1, "R8 release ok", 512'(ok), 512'(1));
        cpu(3'd2, 0, 0, 0, 0, rd, ok);
        chk(rd == 32'h23, "R11 head 2", 512'(rd), 512'(32'h23));
        cpu(3'd0, 0, 2, 9, 0, rd, ok);
        chk(rd == mk(16'h0A02)[9*32 +: 32], "R11 second msg", 512'(rd), 512'(mk(16'h0A02)[9*32 +: 32]));
        cpu(3'd4, 0, 0, 0, 0, rd, ok);
        cpu(3'd4, 0, 0, 0, 0, rd, ok);
        chk(ok === 1'b0, "R8 empty release refused", 512'(ok), 0);
        cpu(3'd2, 0, 0, 0, 0, rd, ok);
        chk(rd[0] === 1'b0, "R8 queue empty", 512'(rd), 512'(2));
    endtask

    task automatic t_full();
        logic [31:0] rd; logic ok; logic r;
        for (int i = 1; i <= 3; i++) rx_push(1, mk(16'h0B00 + 16'(i)), r);
        probe_ready(1, r);
        chk(r === 1'b0, "R4 full not ready", 512'(r), 0);
        rx_push(1, mk(16'h0BFF), r);
        chk(r === 1'b0, "R4 refused arrival", 512'(r), 0);
        probe_ready(0, r);
        chk(r === 1'b1, "R4 other dest ready", 512'(r), 512'(1));
        cpu(3'd4, 1, 0, 0, 0, rd, ok);
        rx_push(1, mk(16'h0B04), r);
        chk(r === 1'b1, "R4 ready after release", 512'(r), 512'(1));
        cpu(3'd2, 1, 0, 0, 0, rd, ok);
        chk(rd[5:4] == 2'd2, "R11 order 2", 512'(rd[5:4]), 512'(2));
        cpu(3'd4, 1, 0, 0, 0, rd, ok);
        cpu(3'd4, 1, 0, 0, 0, rd, ok);
        cpu(3'd2, 1, 0, 0, 0, rd, ok);
        chk(rd[5:4] == 2'd1, "R3 reused lowest slot", 512'(rd[5:4]), 512'(1));
        cpu(3'd0, 1, 1, 0, 0, rd, ok);
        chk(rd == mk(16'h0B04)[31:0], "R4 not overwritten", 512'(rd), 512'(mk(16'h0B04)[31:0]));
        cpu(3'd4, 1, 0, 0, 0, rd, ok);
    endtask

    task automatic t_send();
        logic [31:0] rd; logic ok;
        load_stage(0, mk(16'h0C00));
        cpu(3'd3, 0, 0, 0, 0, rd, ok);
        chk(ok === 1'b1, "R5 send accepted", 512'(ok), 512'(1));
        cpu(3'd3, 0, 0, 0, 0, rd, ok);
        chk(ok === 1'b0, "R6 second send refused", 512'(ok), 0);
        cpu(3'd2, 0, 0, 0, 0, rd, ok);
        chk(rd[1] === 1'b0, "R5 cannot send", 512'(rd), 0);
        repeat (3) @(negedge clk);
        chk(net_tx_valid === 1'b1 && net_tx_data == mk(16'h0C00), "R7 held", net_tx_data, mk(16'h0C00));
        tx_take(0, mk(16'h0C00), "R5");
        repeat (2) @(negedge clk);
        chk(net_tx_valid === 1'b0, "R6 no extra message", 512'(net_tx_valid), 0);
        cpu(3'd2, 0, 0, 0, 0, rd, ok);
        chk(rd[1] === 1'b1, "R5 can send again", 512'(rd), 512'(2));
    endtask

    task automatic t_forward();
        logic [31:0] rd; logic ok; logic r;
        for (int i = 1; i <= 3; i++) rx_push(1, mk(16'h0D00 + 16'(i)), r);
        cpu(3'd5, 1, 0, 0, 0, rd, ok);
        chk(ok === 1'b1, "R9 forward accepted", 512'(ok), 512'(1));
        cpu(3'd5, 1, 0, 0, 0, rd, ok);
        chk(ok === 1'b0, "R6 forward refused", 512'(ok), 0);
        probe_ready(1, r);
        chk(r === 1'b0, "R9 slot held until sent", 512'(r), 0);
        tx_take(1, mk(16'h0D01), "R9");
        probe_ready(1, r);
        chk(r === 1'b1, "R9 slot freed", 512'(r), 512'(1));
        cpu(3'd2, 1, 0, 0, 0, rd, ok);
        chk(rd[5:4] == 2'd2, "R9 head advanced", 512'(rd[5:4]), 512'(2));
        cpu(3'd4, 1, 0, 0, 0, rd, ok);
        cpu(3'd4, 1, 0, 0, 0, rd, ok);
    endtask

    task automatic t_round_robin();
        logic [31:0] rd; logic ok;
        for (int c = 0; c < 3; c++) load_stage(c, mk(16'h0E00 + 16'(c)));
        cpu(3'd3, 0, 0, 0, 0, rd, ok);
        repeat (2) @(negedge clk);
        cpu(3'd3, 1, 0, 0, 0, rd, ok);
        cpu(3'd3, 2, 0, 0, 0, rd, ok);
        tx_take(0, mk(16'h0E00), "R10 first");
        cpu(3'd3, 0, 0, 0, 0, rd, ok);
        chk(ok === 1'b1, "R10 resend accepted", 512'(ok), 512'(1));
        tx_take(1, mk(16'h0E01), "R10 second");
        tx_take(2, mk(16'h0E02), "R10 third");
        tx_take(0, mk(16'h0E00), "R10 wrap");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_word_rw();
        t_arrival();
        t_full();
        t_send();
        t_forward();
        t_round_robin();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule